// File: doc/BRIEF.md
# Core Supply Level and Hibernate Sequencer

This block is the power-state controller for a processor core. Software programs a control word with three fields. The first is a target supply level, and the supply level applied to the regulator follows it. The second is a two-bit regulator mode. The third holds one wake-enable bit for each external wake source. A separate register holds a relock count that stands in for the PLL settling time.

A change of target level does not take effect at once. It waits until the core reports idle. The applied level then switches, the clock generator goes into a bypass state, and the relock timer runs before full operation resumes.

Writing the "off" mode code shuts the regulator down. Both clocks are gated and the supply enable drops. The block then waits for a synchronized wake request from a source whose enable bit is set. On wake it restores the supply and runs the same relock. It raises a ready strobe in the last relock cycle, and the clocks come back in the next cycle. The asynchronous reset also ends hibernate.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the state is FULL_ON (state code 0, PENDING 1, RELOCK 2, HIBERNATE 3). Both clock enables and the supply enable are high and pll_bypass is low. ctrl_rd reads 9'h02D: mode 2'b01 in bits [1:0], level 4'b1011 in bits [5:2], and wake enables 0 in bits [8:6]. lock_rd reads 64, wake_status reads 0 and vlev_out reads 4'b1011.
- R2: A control write whose level field differs from vlev_out moves the state to PENDING one cycle after the write. vlev_out keeps its old value for as long as core_idle stays low.
- R3: A cycle in PENDING with core_idle high moves the state to RELOCK at the next edge. On that edge vlev_out takes the target level and pll_bypass rises, while both clocks keep running.
- R4: A relock lasts exactly max(L,1) cycles, where L is the relock count (register address 1) at entry. The state then returns to FULL_ON, so a count of 0 behaves as 1.
- R5: In FULL_ON, a mode field of 2'b00 moves the state to HIBERNATE on the next edge. In HIBERNATE, cclk_en, sclk_en and supply_en are all low.
- R6: wake_req bit 0, 1 and 2 are paired with enable bits 6, 7 and 8 of the control word. A request leaves HIBERNATE only when its enable bit is set. It passes through a two-stage synchronizer, so the state becomes RELOCK on the third edge after the request rises.
- R7: While in HIBERNATE, writes to every address are ignored.
- R8: On wake, supply_en rises on entry to RELOCK while both clocks stay gated. ready is high only in the last relock cycle, and the clocks return on the next cycle in FULL_ON. The mode field reads back 2'b01.
- R9: On wake, wake_status (bit order as wake_req) latches the enabled sources that caused it. Writing a 1 to a bit at address 2 clears that bit.
- R10: Asserting rst_n low ends HIBERNATE whatever the enable bits are, and the block returns to its reset values.
- R11: If, while PENDING, the target level is rewritten equal to vlev_out, the state returns to FULL_ON on the next edge without a relock, and vlev_out does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 relock count, 2 status clear |
| wr_data | input | 16 | Write data |
| core_idle | input | 1 | Core has executed idle |
| wake_req | input | 3 | Asynchronous wake requests (0 timer, 1 general-purpose, 2 PHY) |
| ctrl_rd | output | 9 | Control word read-back |
| lock_rd | output | 16 | Relock count read-back |
| wake_status | output | 3 | Sticky wake cause |
| state | output | 2 | Current power state |
| vlev_out | output | 4 | Applied supply level to the regulator |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| supply_en | output | 1 | Core supply enable |
| pll_bypass | output | 1 | Clock generator in bypass during relock |
| ready | output | 1 | Last wake-relock cycle strobe |

## Verification
The relock-length check assumes that the relock count is not rewritten while a relock is running. It also takes for granted that wake requests are steady levels lasting well beyond the synchronizer. The stimulus writes the count only in FULL_ON and holds every wake request for several cycles before releasing it. The hibernate sweep covers every combination of enable bits against every source. For disabled sources it escapes through reset.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PS_FULL_ON   = 2'd0,
    PS_PENDING   = 2'd1,
    PS_RELOCK    = 2'd2,
    PS_HIBERNATE = 2'd3
  } pstate_e;

  localparam int          MODE_W    = 2;
  localparam logic [1:0]  MODE_OFF  = 2'b00;
  localparam logic [1:0]  MODE_WAKE = 2'b01;
  localparam logic [1:0]  ADDR_CTRL = 2'd0;
  localparam logic [1:0]  ADDR_LOCK = 2'd1;
  localparam logic [1:0]  ADDR_STAT = 2'd2;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] async_i,
  output logic [NSRC-1:0] sync_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int LCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LCNT_W-1:0] count_i,
  output logic              last_o
);
  localparam logic [LCNT_W-1:0] ONE = LCNT_W'(1);

  logic [LCNT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q > ONE);
    if (load_i) cnt_d = (count_i == '0) ? ONE : count_i;
    else        cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ONE;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs
  import pwrseq_pkg::*;
#(
  parameter int                VLEV_W   = 4,
  parameter int                NSRC     = 3,
  parameter int                LCNT_W   = 16,
  parameter int                DATA_W   = 16,
  parameter logic [VLEV_W-1:0] RST_VLEV = 4'b1011,
  parameter logic [LCNT_W-1:0] LCNT_RST = 16'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mode_restore_i,
  input  logic [NSRC-1:0]   stat_set_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [VLEV_W-1:0] vlev_tgt_o,
  output logic [NSRC-1:0]   wake_en_o,
  output logic [LCNT_W-1:0] lock_o,
  output logic [NSRC-1:0]   stat_o
);
  localparam int CTRL_W = MODE_W + VLEV_W + NSRC;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [VLEV_W-1:0] vlev_q;
  logic [NSRC-1:0]   en_q;
  logic [LCNT_W-1:0] lock_q;
  logic [NSRC-1:0]   stat_q, stat_d;
  logic              ctrl_we, lock_we, stat_we, mode_en, stat_en;

  always_comb begin
    ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);
    lock_we = wr_en_i && (wr_addr_i == ADDR_LOCK);
    stat_we = wr_en_i && (wr_addr_i == ADDR_STAT);
    mode_en = ctrl_we || mode_restore_i;
    mode_d  = mode_restore_i ? MODE_WAKE : wr_data_i[MODE_W-1:0];
    stat_en = stat_we || (stat_set_i != '0);
    stat_d  = stat_set_i | (stat_we ? (stat_q & ~wr_data_i[NSRC-1:0]) : stat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_WAKE;
      vlev_q <= RST_VLEV;
      en_q   <= '0;
      lock_q <= LCNT_RST;
      stat_q <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (ctrl_we) begin
        vlev_q <= wr_data_i[MODE_W +: VLEV_W];
        en_q   <= wr_data_i[MODE_W+VLEV_W +: NSRC];
      end
      if (lock_we) lock_q <= wr_data_i[LCNT_W-1:0];
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign mode_o     = mode_q;
  assign vlev_tgt_o = vlev_q;
  assign wake_en_o  = en_q;
  assign lock_o     = lock_q;
  assign stat_o     = stat_q;

  if (CTRL_W > DATA_W) begin : g_bad_width
    initial $error("control word wider than write data");
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int                VLEV_W   = 4,
  parameter int                NSRC     = 3,
  parameter int                LCNT_W   = 16,
  parameter int                DATA_W   = 16,
  parameter logic [VLEV_W-1:0] RST_VLEV = 4'b1011,
  parameter logic [LCNT_W-1:0] LCNT_RST = 16'd64,
  localparam int               CTRL_W   = MODE_W + VLEV_W + NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              core_idle,
  input  logic [NSRC-1:0]   wake_req,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [LCNT_W-1:0] lock_rd,
  output logic [NSRC-1:0]   wake_status,
  output logic [1:0]        state,
  output logic [VLEV_W-1:0] vlev_out,
  output logic              cclk_en,
  output logic              sclk_en,
  output logic              supply_en,
  output logic              pll_bypass,
  output logic              ready
);
  pstate_e           state_q, state_d;
  logic [VLEV_W-1:0] vlev_q, vlev_d;
  logic              waking_q, waking_d;
  logic              apply_en, waking_en;
  logic [MODE_W-1:0] mode;
  logic [VLEV_W-1:0] vlev_tgt;
  logic [NSRC-1:0]   wake_en, wake_sync_s, wake_hit;
  logic [LCNT_W-1:0] lock_val;
  logic              relock_last, load_timer, restore_mode;
  logic [NSRC-1:0]   stat_set;
  logic              reg_we;

  assign reg_we = wr_en && (state_q != PS_HIBERNATE);

  pwr_ctrl_regs #(
    .VLEV_W(VLEV_W), .NSRC(NSRC), .LCNT_W(LCNT_W), .DATA_W(DATA_W),
    .RST_VLEV(RST_VLEV), .LCNT_RST(LCNT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_we), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .mode_restore_i(restore_mode), .stat_set_i(stat_set),
    .mode_o(mode), .vlev_tgt_o(vlev_tgt), .wake_en_o(wake_en),
    .lock_o(lock_val), .stat_o(wake_status)
  );

  wake_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(wake_req), .sync_o(wake_sync_s)
  );

  lock_timer #(.LCNT_W(LCNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load_timer), .count_i(lock_val),
    .last_o(relock_last)
  );

  assign wake_hit = wake_sync_s & wake_en;

  always_comb begin
    state_d      = state_q;
    vlev_d       = vlev_q;
    waking_d     = waking_q;
    apply_en     = 1'b0;
    waking_en    = 1'b0;
    load_timer   = 1'b0;
    restore_mode = 1'b0;
    stat_set     = '0;
    unique case (state_q)
      PS_FULL_ON: begin
        if (mode == MODE_OFF)       state_d = PS_HIBERNATE;
        else if (vlev_tgt != vlev_q) state_d = PS_PENDING;
      end
      PS_PENDING: begin
        if (vlev_tgt == vlev_q) begin
          state_d = PS_FULL_ON;
        end else if (core_idle) begin
          state_d    = PS_RELOCK;
          vlev_d     = vlev_tgt;
          apply_en   = 1'b1;
          waking_d   = 1'b0;
          waking_en  = 1'b1;
          load_timer = 1'b1;
        end
      end
      PS_RELOCK: begin
        if (relock_last) state_d = PS_FULL_ON;
      end
      PS_HIBERNATE: begin
        if (wake_hit != '0) begin
          state_d      = PS_RELOCK;
          waking_d     = 1'b1;
          waking_en    = 1'b1;
          load_timer   = 1'b1;
          restore_mode = 1'b1;
          stat_set     = wake_hit;
        end
      end
      default: state_d = PS_FULL_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_FULL_ON;
      vlev_q   <= RST_VLEV;
      waking_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (apply_en)  vlev_q   <= vlev_d;
      if (waking_en) waking_q <= waking_d;
    end
  end

  logic clocks_on;
  assign clocks_on  = (state_q == PS_FULL_ON) || (state_q == PS_PENDING) ||
                      ((state_q == PS_RELOCK) && !waking_q);
  assign cclk_en    = clocks_on;
  assign sclk_en    = clocks_on;
  assign supply_en  = (state_q != PS_HIBERNATE);
  assign pll_bypass = (state_q == PS_RELOCK);
  assign ready      = (state_q == PS_RELOCK) && waking_q && relock_last;
  assign state      = state_q;
  assign vlev_out   = vlev_q;
  assign ctrl_rd    = {wake_en, vlev_tgt, mode};
  assign lock_rd    = lock_val;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int VLEV_W = 4,
  parameter int NSRC   = 3,
  parameter int LCNT_W = 16,
  parameter int CTRL_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_idle,
  input logic [1:0]        state_o,
  input logic [VLEV_W-1:0] vlev_out,
  input logic              cclk_en,
  input logic              sclk_en,
  input logic              supply_en,
  input logic              ready,
  input logic [CTRL_W-1:0] ctrl_rd,
  input logic [LCNT_W-1:0] lock_rd,
  input logic [NSRC-1:0]   wake_status
);
  localparam logic [1:0] S_PEND = 2'd1, S_RL = 2'd2, S_HIB = 2'd3, S_ON = 2'd0;

  logic              in_rl_q;
  logic [LCNT_W:0]   run_q, tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rl_q <= 1'b0;
      run_q   <= '0;
      tgt_q   <= '0;
    end else begin
      in_rl_q <= (state_o == S_RL);
      if (state_o == S_RL) run_q <= in_rl_q ? run_q + 1'b1 : (LCNT_W+1)'(1);
      else                 run_q <= '0;
      if (state_o == S_RL && !in_rl_q)
        tgt_q <= (lock_rd == '0) ? (LCNT_W+1)'(1) : {1'b0, lock_rd};
    end
  end

  a_r2_level_only_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vlev_out) |-> ($past(state_o) == S_PEND && $past(core_idle)));

  a_r4_relock_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_RL && in_rl_q) |-> (run_q < tgt_q));

  a_r4_relock_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rl_q && state_o != S_RL) |-> (run_q == tgt_q));

  a_r5_hib_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_HIB) |-> (!cclk_en && !sclk_en && !supply_en));

  a_r6_hib_exit_via_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_HIB) |=> (state_o == S_HIB || state_o == S_RL));

  a_r7_hib_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_HIB) |=> (state_o != S_HIB || ($stable(ctrl_rd) && $stable(lock_rd))));

  a_r8_ready_then_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (state_o == S_ON && cclk_en && sclk_en));

  a_r9_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_status & ~$past(wake_status)) != '0) |->
      ($past(state_o) == S_HIB &&
       ((wake_status & ~$past(wake_status) & ~$past(ctrl_rd[CTRL_W-1 -: NSRC])) == '0)));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(
  .VLEV_W(VLEV_W), .NSRC(NSRC), .LCNT_W(LCNT_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_idle(core_idle), .state_o(state),
  .vlev_out(vlev_out), .cclk_en(cclk_en), .sclk_en(sclk_en),
  .supply_en(supply_en), .ready(ready), .ctrl_rd(ctrl_rd), .lock_rd(lock_rd),
  .wake_status(wake_status)
);

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        core_idle;
  logic [2:0]  wake_req;
  logic [8:0]  ctrl_rd;
  logic [15:0] lock_rd;
  logic [2:0]  wake_status;
  logic [1:0]  state;
  logic [3:0]  vlev_out;
  logic        cclk_en, sclk_en, supply_en, pll_bypass, ready;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .core_idle(core_idle), .wake_req(wake_req),
    .ctrl_rd(ctrl_rd), .lock_rd(lock_rd), .wake_status(wake_status),
    .state(state), .vlev_out(vlev_out), .cclk_en(cclk_en), .sclk_en(sclk_en),
    .supply_en(supply_en), .pll_bypass(pll_bypass), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 state on reset", {30'd0, state}, 32'd0);
    check("R10 supply on reset", {31'd0, supply_en}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] cur_v;
    logic [3:0] new_v;
    int n;
    int exp_len;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    core_idle = 1'b0; wake_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    check("R1 state", {30'd0, state}, 32'd0);
    check("R1 ctrl", {23'd0, ctrl_rd}, 32'h2D);
    check("R1 lock", {16'd0, lock_rd}, 32'd64);
    check("R1 status", {29'd0, wake_status}, 32'd0);
    check("R1 vlev", {28'd0, vlev_out}, 32'hB);
    check("R1 enables", {28'd0, cclk_en, sclk_en, supply_en, pll_bypass}, 32'hE);
    cur_v = 4'b1011;

    // voltage change sweep over relock counts 0..4
    for (int L = 0; L < 5; L++) begin
      wr(2'd1, 16'(L));
      new_v = (L % 2 == 0) ? 4'b1111 : 4'b1110;
      wr(2'd0, {7'd0, new_v, 2'b01});
      @(negedge clk);
      check("R2 pending", {30'd0, state}, 32'd1);
      repeat (3) @(negedge clk);
      check("R2 still pending", {30'd0, state}, 32'd1);
      check("R2 level held", {28'd0, vlev_out}, {28'd0, cur_v});
      core_idle = 1'b1;
      @(negedge clk);
      core_idle = 1'b0;
      check("R3 relock", {30'd0, state}, 32'd2);
      check("R3 level applied", {28'd0, vlev_out}, {28'd0, new_v});
      check("R3 bypass+clocks", {29'd0, pll_bypass, cclk_en, sclk_en}, 32'd7);
      n = 0;
      while (state == 2'd2 && n < 100) begin
        n++;
        @(negedge clk);
      end
      exp_len = (L == 0) ? 1 : L;
      check("R4 relock length", n, exp_len);
      check("R4 back to full on", {30'd0, state}, 32'd0);
      cur_v = new_v;
    end

    // R11 cancel a pending change
    wr(2'd0, {7'd0, 4'b0101, 2'b01});
    check("R11 pending", {30'd0, state}, 32'd0);
    @(negedge clk);
    check("R11 pending", {30'd0, state}, 32'd1);
    wr(2'd0, {7'd0, cur_v, 2'b01});
    @(negedge clk);
    check("R11 returned", {30'd0, state}, 32'd0);
    check("R11 level kept", {28'd0, vlev_out}, {28'd0, cur_v});

    // hibernate sweep: every enable mask against every source
    wr(2'd1, 16'd2);
    for (int en = 0; en < 8; en++) begin
      for (int src = 0; src < 3; src++) begin
        wr(2'd0, {7'd0, 3'(en), cur_v, 2'b00});
        @(negedge clk);
        check("R5 hibernate", {30'd0, state}, 32'd3);
        check("R5 all off", {29'd0, cclk_en, sclk_en, supply_en}, 32'd0);
        wr(2'd1, 16'd9);
        wr(2'd0, {7'd0, 3'(en), cur_v, 2'b01});
        wr(2'd2, 16'h7);
        check("R7 lock frozen", {16'd0, lock_rd}, 32'd2);
        check("R7 mode frozen", {30'd0, ctrl_rd[1:0]}, 32'd0);
        check("R7 still hibernate", {30'd0, state}, 32'd3);
        @(negedge clk);
        wake_req[src] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 sync delay", {30'd0, state}, 32'd3);
        @(negedge clk);
        if (en[src]) begin
          check("R6 woke", {30'd0, state}, 32'd2);
          check("R8 supply up clocks gated", {29'd0, supply_en, cclk_en, sclk_en}, 32'd4);
          check("R8 ready not yet", {31'd0, ready}, 32'd0);
          @(negedge clk);
          check("R8 ready last cycle", {30'd0, ready, cclk_en}, 32'd2);
          @(negedge clk);
          check("R8 clocks back", {29'd0, state == 2'd0, cclk_en, sclk_en}, 32'd7);
          check("R8 mode restored", {30'd0, ctrl_rd[1:0]}, 32'd1);
          check("R9 status", {29'd0, wake_status}, 32'(1 << src));
          wake_req = '0;
          wr(2'd2, 16'(1 << src));
          check("R9 cleared", {29'd0, wake_status}, 32'd0);
        end else begin
          check("R6 not enabled", {30'd0, state}, 32'd3);
          wake_req = '0;
          do_reset();
          @(negedge clk);
          check("R10 after reset", {23'd0, ctrl_rd}, 32'h2D);
          cur_v = 4'b1011;
          wr(2'd1, 16'd2);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule